// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit load/store pipeline stage and a data memory that is one word wide. For a store it takes a byte address, an access size and the store data. It returns the word address, one write enable for each byte lane, and the store data shifted into the lanes the access covers. For a load it takes the word the memory returned. It picks out the addressed byte or halfword and widens it to 32 bits, either with sign extension or with zero fill. The word is returned unchanged for a word load.

A run-time input selects the byte numbering. With little-endian numbering, byte offset 0 is the least significant lane. With big-endian numbering, byte offset 0 is the most significant lane. An access is aligned only when its byte address is a multiple of its size. A misaligned access raises a fault output and produces neither a write nor load data.

The logic is combinational. A parameter can add one register stage on the outputs.

Top module: `lsu_lane_align`

## Requirements
- R1: For a valid request, word_addr_o equals addr_i with its two low bits cleared. While req_valid_i is low, every output is zero.
- R2: Access size is encoded as 00 byte, 01 halfword, 10 word and 11 unsupported. fault_o rises when addr_i mod size is not 0: halfword with addr_i[0]=1, or word with addr_i[1:0]≠0. It also rises for size code 11. A byte access never faults.
- R3: A faulting request drives be_o, wdata_o and rdata_o to zero.
- R4: A byte store enables a single lane, lane k being bits 8k+7:8k. The lane is k=offset in little-endian mode and k=3−offset in big-endian mode. wdata_i[7:0] is placed in that lane and every other lane is zero.
- R5: A halfword store enables two adjacent lanes. These are lanes offset and offset+1 in little-endian mode, with wdata_i[15:0] at bits 8·offset+15:8·offset. They are lanes 2−offset and 3−offset in big-endian mode, with wdata_i[15:0] at bits 8·(2−offset)+15:8·(2−offset). All other lanes are zero.
- R6: An aligned word store enables all four lanes and passes wdata_i unchanged in either endian mode.
- R7: A byte load returns the lane chosen as in R4. The upper 24 bits copy the byte's top bit when signed_i=1 and are zero when signed_i=0.
- R8: A halfword load returns the lane pair chosen as in R5, as a 16-bit value. The upper 16 bits copy its top bit when signed_i=1 and are zero when signed_i=0.
- R9: An aligned word load returns rdata_i unchanged in either endian mode.
- R10: A load drives be_o and wdata_o to zero. A store drives rdata_o to zero.
- R11: With REG_OUT=1 the outputs reflect the request one clock edge after it is presented. An active-low asynchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | 1 selects big-endian byte numbering |
| req_valid_i | input | 1 | Request present this cycle |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| size_i | input | 2 | Access size code (R2) |
| signed_i | input | 1 | Sign-extend sub-word loads |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data, right-aligned |
| rdata_i | input | 32 | Word returned by memory for this address |
| word_addr_o | output | ADDR_W | Word-aligned address |
| be_o | output | 4 | Per-lane write enables |
| wdata_o | output | 32 | Lane-steered store data |
| rdata_o | output | 32 | Extracted and extended load data |
| fault_o | output | 1 | Misaligned or unsupported access |

## Verification
The properties take for granted that rdata_i is the memory word for the same address as the request. They also take for granted that it is presented together with the request in the same cycle. The properties never judge which lane a given address should map to. They check only output-side consistency: a fault disables all writes, enabled lanes form a legal pattern, and idle cycles stay quiet. The stimulus holds every input steady from one falling edge to the next. It changes nothing near a rising edge, so each request is registered exactly once. The vector table covers both endian modes, every size code, signed and unsigned loads, and aligned and misaligned offsets, including the highest byte offset.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
(
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic               fault_o
);
    always_comb begin
        unique case (size_i)
            SZ_BYTE: fault_o = 1'b0;
            SZ_HALF: fault_o = off_i[0];
            SZ_WORD: fault_o = |off_i;
            default: fault_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import lsu_lane_pkg::*;
(
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic               big_endian_i,
    output logic [OFF_W-1:0]   base_o,
    output logic [LANES-1:0]   mask_o
);
    localparam logic [OFF_W-1:0] TOP_LANE  = OFF_W'(LANES - 1);
    localparam logic [OFF_W-1:0] HALF_TOP  = OFF_W'(LANES - 2);
    localparam logic [LANES-1:0] ONE_LANE  = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANES = LANES'(3);

    always_comb begin
        base_o = '0;
        mask_o = '0;
        unique case (size_i)
            SZ_BYTE: begin
                base_o = big_endian_i ? (TOP_LANE - off_i) : off_i;
                mask_o = ONE_LANE << base_o;
            end
            SZ_HALF: begin
                base_o = big_endian_i ? (HALF_TOP - off_i) : off_i;
                mask_o = TWO_LANES << base_o;
            end
            SZ_WORD: begin
                base_o = '0;
                mask_o = '1;
            end
            default: begin
                base_o = '0;
                mask_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_lane_pkg::*;
(
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [OFF_W-1:0]   base_i,
    input  logic [LANES-1:0]   mask_i,
    output logic [DATA_W-1:0]  wdata_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(k);
        logic [OFF_W-1:0] src_idx;
        assign src_idx = LANE_IDX - base_i;
        assign wdata_o[k*BYTE_W +: BYTE_W] =
            mask_i[k] ? wdata_i[src_idx*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  logic [DATA_W-1:0]  rdata_i,
    input  logic [OFF_W-1:0]   base_i,
    input  acc_size_e          size_i,
    input  logic               signed_i,
    output logic [DATA_W-1:0]  value_o
);
    localparam int HALF_W = 2 * BYTE_W;

    logic [DATA_W-1:0] shifted;
    logic              byte_top;
    logic              half_top;

    assign shifted  = rdata_i >> (BYTE_W * base_i);
    assign byte_top = signed_i & shifted[BYTE_W-1];
    assign half_top = signed_i & shifted[HALF_W-1];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: value_o = {{(DATA_W-BYTE_W){byte_top}}, shifted[BYTE_W-1:0]};
            SZ_HALF: value_o = {{(DATA_W-HALF_W){half_top}}, shifted[HALF_W-1:0]};
            default: value_o = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic              req_valid_i,
    input  logic              is_store_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              fault_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] word_addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              fault;
    } lane_out_t;

    acc_size_e         size_e;
    logic [OFF_W-1:0]  off;
    logic              misalign;
    logic [OFF_W-1:0]  lane_base;
    logic [LANES-1:0]  lane_mask;
    logic [DATA_W-1:0] steered;
    logic [DATA_W-1:0] extracted;
    lane_out_t         out_d;
    lane_out_t         out_q;

    assign size_e = acc_size_e'(size_i);
    assign off    = addr_i[OFF_W-1:0];

    lsu_align_check u_check (
        .size_i  (size_e),
        .off_i   (off),
        .fault_o (misalign)
    );

    lsu_lane_map u_map (
        .size_i       (size_e),
        .off_i        (off),
        .big_endian_i (big_endian_i),
        .base_o       (lane_base),
        .mask_o       (lane_mask)
    );

    lsu_store_steer u_steer (
        .wdata_i (wdata_i),
        .base_i  (lane_base),
        .mask_i  (lane_mask),
        .wdata_o (steered)
    );

    lsu_load_extract u_extract (
        .rdata_i  (rdata_i),
        .base_i   (lane_base),
        .size_i   (size_e),
        .signed_i (signed_i),
        .value_o  (extracted)
    );

    always_comb begin
        out_d = '0;
        if (req_valid_i) begin
            out_d.word_addr = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            out_d.fault     = misalign;
            if (!misalign) begin
                if (is_store_i) begin
                    out_d.be    = lane_mask;
                    out_d.wdata = steered;
                end else begin
                    out_d.rdata = extracted;
                end
            end
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign word_addr_o = out_q.word_addr;
    assign be_o        = out_q.be;
    assign wdata_o     = out_q.wdata;
    assign rdata_o     = out_q.rdata;
    assign fault_o     = out_q.fault;
endmodule

// File: rtl/lsu_lane_align_sva.sv
module lsu_lane_align_sva
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] word_addr_o,
    input logic [LANES-1:0]  be_o,
    input logic [DATA_W-1:0] wdata_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              fault_o
);
    // R3: a fault leaves no write and no load data
    assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (be_o == '0 && wdata_o == '0 && rdata_o == '0));

    // R1: the word address never carries byte offset bits
    assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_addr_o[OFF_W-1:0] == '0);

    // R5: enabled lanes count is 0, 1, 2 or all
    assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(be_o) == 0 || $countones(be_o) == 1 ||
         $countones(be_o) == 2 || $countones(be_o) == LANES));

    // R10: a write never comes with load data
    assert_dir_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (be_o != '0) |-> (rdata_o == '0));

    // R4: lanes without an enable carry zero data
    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !be_o[k] |-> (wdata_o[k*BYTE_W +: BYTE_W] == '0));
    end

    if (REG_OUT) begin : g_lat
        // R11: an idle cycle yields quiet outputs one edge later
        assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req_valid_i) |-> (be_o == '0 && !fault_o && rdata_o == '0));
    end
endmodule

bind lsu_lane_align lsu_lane_align_sva #(
    .ADDR_W  (ADDR_W),
    .REG_OUT (REG_OUT)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .word_addr_o (word_addr_o),
    .be_o        (be_o),
    .wdata_o     (wdata_o),
    .rdata_o     (rdata_o),
    .fault_o     (fault_o)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
    typedef struct packed {
        logic        val;
        logic        big;
        logic        st;
        logic [1:0]  sz;
        logic        sg;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic [31:0] erd;
        logic        eflt;
    } vec_t;

    localparam logic [31:0] RW = 32'h8A7B_C6F5;
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,2'd0,1'b1,32'h100,32'h0,RW,4'b0000,32'h0,32'hFFFF_FFF5,1'b0},
        '{1'b1,1'b0,1'b0,2'd0,1'b0,32'h103,32'h0,RW,4'b0000,32'h0,32'h0000_008A,1'b0},
        '{1'b1,1'b1,1'b0,2'd0,1'b1,32'h101,32'h0,RW,4'b0000,32'h0,32'h0000_007B,1'b0},
        '{1'b1,1'b1,1'b0,2'd0,1'b1,32'h103,32'h0,RW,4'b0000,32'h0,32'hFFFF_FFF5,1'b0},
        '{1'b1,1'b0,1'b0,2'd1,1'b1,32'h102,32'h0,RW,4'b0000,32'h0,32'hFFFF_8A7B,1'b0},
        '{1'b1,1'b0,1'b0,2'd1,1'b0,32'h100,32'h0,RW,4'b0000,32'h0,32'h0000_C6F5,1'b0},
        '{1'b1,1'b1,1'b0,2'd1,1'b1,32'h102,32'h0,RW,4'b0000,32'h0,32'hFFFF_C6F5,1'b0},
        '{1'b1,1'b1,1'b0,2'd1,1'b0,32'h100,32'h0,RW,4'b0000,32'h0,32'h0000_8A7B,1'b0},
        '{1'b1,1'b0,1'b0,2'd2,1'b0,32'h104,32'h0,RW,4'b0000,32'h0,RW,1'b0},
        '{1'b1,1'b1,1'b0,2'd2,1'b1,32'h108,32'h0,RW,4'b0000,32'h0,RW,1'b0},
        '{1'b1,1'b0,1'b0,2'd1,1'b1,32'h101,32'h0,RW,4'b0000,32'h0,32'h0,1'b1},
        '{1'b1,1'b0,1'b1,2'd0,1'b0,32'h201,32'h1234_56AB,RW,4'b0010,32'h0000_AB00,32'h0,1'b0},
        '{1'b1,1'b1,1'b1,2'd0,1'b0,32'h201,32'h1234_56AB,RW,4'b0100,32'h00AB_0000,32'h0,1'b0},
        '{1'b1,1'b0,1'b1,2'd1,1'b0,32'h202,32'h1234_CDEF,RW,4'b1100,32'hCDEF_0000,32'h0,1'b0},
        '{1'b1,1'b1,1'b1,2'd1,1'b0,32'h202,32'h1234_CDEF,RW,4'b0011,32'h0000_CDEF,32'h0,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,32'h200,32'hDEAD_BEEF,RW,4'b1111,32'hDEAD_BEEF,32'h0,1'b0},
        '{1'b1,1'b0,1'b1,2'd2,1'b0,32'h206,32'hDEAD_BEEF,RW,4'b0000,32'h0,32'h0,1'b1},
        '{1'b1,1'b0,1'b1,2'd3,1'b0,32'h200,32'hDEAD_BEEF,RW,4'b0000,32'h0,32'h0,1'b1},
        '{1'b1,1'b1,1'b0,2'd2,1'b0,32'h202,32'h0,RW,4'b0000,32'h0,32'h0,1'b1},
        '{1'b1,1'b0,1'b1,2'd0,1'b0,32'h2FF,32'h1234_56AB,RW,4'b1000,32'hAB00_0000,32'h0,1'b0},
        '{1'b0,1'b0,1'b1,2'd2,1'b0,32'h300,32'h5555_AAAA,RW,4'b0000,32'h0,32'h0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        is_store_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic        signed_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_i = '0;
    logic [31:0] word_addr_o;
    logic [3:0]  be_o;
    logic [31:0] wdata_o;
    logic [31:0] rdata_o;
    logic        fault_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lsu_lane_align #(.ADDR_W(32), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
        .req_valid_i(req_valid_i), .is_store_i(is_store_i), .size_i(size_i),
        .signed_i(signed_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_i(rdata_i),
        .word_addr_o(word_addr_o), .be_o(be_o), .wdata_o(wdata_o),
        .rdata_o(rdata_o), .fault_o(fault_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (!v.val)  return "R1";
        if (v.eflt)  return "R2";
        if (v.st) begin
            if (v.sz == 2'd0) return "R4";
            if (v.sz == 2'd1) return "R5";
            return "R6";
        end
        if (v.sz == 2'd0) return "R7";
        if (v.sz == 2'd1) return "R8";
        return "R9";
    endfunction

    task automatic apply(input vec_t v);
        req_valid_i  = v.val;
        big_endian_i = v.big;
        is_store_i   = v.st;
        size_i       = v.sz;
        signed_i     = v.sg;
        addr_i       = v.addr;
        wdata_i      = v.wd;
        rdata_i      = v.rd;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11: reset state
        #25;
        check("R11", "reset be", {28'h0, be_o}, 32'h0);
        check("R11", "reset fault", {31'h0, fault_o}, 32'h0);
        check("R11", "reset rdata", rdata_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v);
            @(negedge clk);
            apply(v);
            @(negedge clk);
            check("R1", "word_addr", word_addr_o, v.val ? (v.addr & ~32'h3) : 32'h0);
            check(v.eflt ? "R3" : t, "fault", {31'h0, fault_o}, {31'h0, v.eflt});
            check(v.st ? t : "R10", "be", {28'h0, be_o}, {28'h0, v.ebe});
            check(v.st ? t : "R10", "wdata", wdata_o, v.ewd);
            check(v.st ? "R10" : t, "rdata", rdata_o, v.erd);
        end

        // R11: one edge of latency, output holds until the next rising edge
        @(negedge clk);
        apply(VECS[15]);
        #2;
        check("R11", "before edge be", {28'h0, be_o}, 32'h0);
        @(negedge clk);
        check("R11", "after edge be", {28'h0, be_o}, 32'hF);

        // R11: asynchronous reset clears registered outputs
        #2;
        rst_n = 1'b0;
        #1;
        check("R11", "async reset be", {28'h0, be_o}, 32'h0);
        check("R11", "async reset wdata", wdata_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        req_valid_i = 1'b0;
        @(negedge clk);
        check("R1", "idle wdata", wdata_o, 32'h0);

        finish_run();
    end
endmodule